// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

The block is a watchdog timer with a small register bus. Software arms it, then has to keep refreshing it. If the refreshes stop, the block raises a reset request. All control goes through a 16-bit key register, and only certain magic values do anything there. Those values arm the counter, refresh it, and open or close write access to the two configuration registers.

A 12-bit down-counter is decremented once per prescaler tick. The prescaler divides the block clock by a power of two between 4 and 256. When the counter passes zero, the block emits a one-cycle reset request and reloads the counter. A new prescaler or reload value does not take effect at once. It becomes active after a fixed settling latency, and a status flag for each register stays busy until the value has landed. Nothing written over the bus can stop the counter once it is armed; only the asynchronous reset can. Offset 0x10 is reserved for a window function that is not built.

Top module: `wdg_top`

## Requirements
- R1: After reset the prescaler code reads 0, the reload value reads 0xFFF, the status reads 0, write access is locked, the counter is stopped and `rst_req_o` is low.
- R2: Key value 0x5555 opens write access and 0x0000 closes it. A write to the prescaler or reload register while access is closed leaves the stored value unchanged.
- R3: A key write with any value other than 0x5555, 0x0000, 0xAAAA or 0xCCCC changes nothing.
- R4: Key value 0xCCCC starts the counter. After that, no bus write stops it.
- R5: Once started, `rst_req_o` is high for exactly one cycle, (reload+1)×divisor clock edges after the start or the last refresh. The counter then reloads and the next pulse follows one period later.
- R6: Key value 0xAAAA reloads the counter and clears the prescaler phase, so that a full period begins.
- R7: Prescaler bits [2:0] hold the code. Codes 0 to 6 select divisors 4, 8, 16, 32, 64, 128 and 256, and code 7 also selects 256. The reload value is held in bits [11:0].
- R8: Status bit 0 (prescaler pending) and status bit 1 (reload pending) read 1 from the edge that accepts a write until 4 cycles later. At that point the new value becomes the one in use.
- R9: The offsets are key 0x00, prescaler 0x04, reload 0x08, status 0x0C and the reserved window 0x10. The key offset, the reserved offset and unmapped offsets all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one write per high cycle |
| rdata_o | output | 16 | Combinational read data for `addr_i` |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions assume that `we_i` is a clean, synchronous strobe and that `addr_i` and `wdata_i` are stable while it is high. They also assume that the divisor is always at least 4, so two reset requests can never fall on adjacent cycles. The stimulus drives every bus signal on the falling edge and lowers `we_i` after each access. It only ever programs legal codes. Before reprogramming a running counter, it places a refresh after every prescaler change, so that every expected pulse cycle can be worked out from the cycle of the refresh.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int RL_W   = 12;
  localparam int PR_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_KEY = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PR  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RL  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_ST  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_WIN = 5'h10;

  localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_LOCK    = 16'h0000;
endpackage

// File: rtl/wdg_keydec.sv
module wdg_keydec
  import wdg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              start_o,
  output logic              refresh_o,
  output logic              unlock_o
);
  logic unlock_q;

  assign start_o   = key_wr_i && (key_i == KEY_START);
  assign refresh_o = key_wr_i && (key_i == KEY_REFRESH);
  assign unlock_o  = unlock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
    end else if (key_wr_i) begin
      if (key_i == KEY_UNLOCK)    unlock_q <= 1'b1;
      else if (key_i == KEY_LOCK) unlock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_cfg_reg.sv
// Bus-visible shadow plus delayed active copy; busy while the copy is in flight.
module wdg_cfg_reg #(
  parameter int          W       = 12,
  parameter int          LAT     = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         busy_o
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAT_C = CW'(LAT);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [W-1:0]  shadow_q, active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
      cnt_q    <= '0;
    end else if (wr_i) begin
      shadow_q <= wdata_i;
      cnt_q    <= LAT_C;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE_C;
      if (cnt_q == ONE_C) active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
  assign busy_o   = (cnt_q != '0);
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int RL_W = 12,
  parameter int PR_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            refresh_i,
  input  logic [PR_W-1:0] pr_code_i,
  input  logic [RL_W-1:0] reload_i,
  output logic            run_o,
  output logic            req_o
);
  localparam int LOG_MIN = 2;
  localparam int LOG_MAX = 8;
  localparam int DIV_W   = LOG_MAX + 1;
  localparam int PRE_W   = LOG_MAX;
  localparam int SH_W    = $clog2(LOG_MAX + 1);
  localparam logic [PR_W-1:0] CODE_MAX = PR_W'(LOG_MAX - LOG_MIN);

  logic [SH_W-1:0]  sh;
  logic [DIV_W-1:0] div;
  logic [PRE_W-1:0] pre_q;
  logic [RL_W-1:0]  cnt_q;
  logic             run_q, req_q, tick;

  always_comb begin
    if (pr_code_i >= CODE_MAX) sh = SH_W'(LOG_MAX);
    else                       sh = SH_W'(pr_code_i) + SH_W'(LOG_MIN);
  end

  assign div  = DIV_W'(1) << sh;
  assign tick = ({1'b0, pre_q} >= (div - DIV_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      req_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= reload_i;
        pre_q <= '0;
      end else if (refresh_i) begin
        cnt_q <= reload_i;
        pre_q <= '0;
      end else if (run_q) begin
        if (tick) begin
          pre_q <= '0;
          if (cnt_q == '0) begin
            req_q <= 1'b1;
            cnt_q <= reload_i;
          end else begin
            cnt_q <= cnt_q - RL_W'(1);
          end
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end

  assign run_o = run_q;
  assign req_o = req_q;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  logic            key_wr, pr_wr, rl_wr;
  logic            start, refresh, unlock, run;
  logic [PR_W-1:0] pr_sh, pr_act;
  logic [RL_W-1:0] rl_sh, rl_act;
  logic [1:0]      busy;

  assign key_wr = we_i && (addr_i == OFS_KEY);
  assign pr_wr  = we_i && unlock && (addr_i == OFS_PR);
  assign rl_wr  = we_i && unlock && (addr_i == OFS_RL);

  wdg_keydec u_key (
    .clk_i, .rst_ni,
    .key_wr_i (key_wr),
    .key_i    (wdata_i),
    .start_o  (start),
    .refresh_o(refresh),
    .unlock_o (unlock)
  );

  wdg_cfg_reg #(.W(PR_W), .LAT(LAT), .RST_VAL('0)) u_pr (
    .clk_i, .rst_ni,
    .wr_i    (pr_wr),
    .wdata_i (wdata_i[PR_W-1:0]),
    .shadow_o(pr_sh),
    .active_o(pr_act),
    .busy_o  (busy[0])
  );

  wdg_cfg_reg #(.W(RL_W), .LAT(LAT), .RST_VAL('1)) u_rl (
    .clk_i, .rst_ni,
    .wr_i    (rl_wr),
    .wdata_i (wdata_i[RL_W-1:0]),
    .shadow_o(rl_sh),
    .active_o(rl_act),
    .busy_o  (busy[1])
  );

  wdg_core #(.RL_W(RL_W), .PR_W(PR_W)) u_core (
    .clk_i, .rst_ni,
    .start_i  (start),
    .refresh_i(refresh),
    .pr_code_i(pr_act),
    .reload_i (rl_act),
    .run_o    (run),
    .req_o    (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_PR:  rdata_o = DATA_W'(pr_sh);
      OFS_RL:  rdata_o = DATA_W'(rl_sh);
      OFS_ST:  rdata_o = DATA_W'(busy);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdg_checks.sv
module wdg_checks
  import wdg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rst_req_o,
  input logic              run_i,
  input logic              unlock_i,
  input logic [1:0]        busy_i,
  input logic [PR_W-1:0]   pr_sh_i,
  input logic [RL_W-1:0]   rl_sh_i
);
  logic odd_key;
  assign odd_key = we_i && (addr_i == OFS_KEY) && (wdata_i != KEY_UNLOCK) &&
                   (wdata_i != KEY_LOCK);

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r5_req_when_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> run_i);
  a_r4_no_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> run_i);
  a_r2_locked_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_RL && !unlock_i) |=> $stable(rl_sh_i));
  a_r2_locked_prescaler: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_PR && !unlock_i) |=> $stable(pr_sh_i));
  a_r3_other_key_keeps_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_key |=> $stable(unlock_i));
  a_r8_reload_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_RL && unlock_i) |=> busy_i[1]);
  a_r8_prescaler_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_PR && unlock_i) |=> busy_i[0]);
endmodule

bind wdg_top wdg_checks u_checks (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rst_req_o(rst_req_o),
  .run_i    (run),
  .unlock_i (unlock),
  .busy_i   (busy),
  .pr_sh_i  (pr_sh),
  .rl_sh_i  (rl_sh)
);

// File: tb/wdg_top_tb_top.sv
`timescale 1ns/100ps
module wdg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_edge = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .rst_req_o(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 last_edge = cyc;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic expect_pulse(input int at);
    exp_q.push_back(at);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: scoreboard for reset-request pulses
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      if (exp_q.size() == 0) check("R5 unexpected pulse", cyc, -1);
      else check("R5 pulse cycle", cyc, exp_q.pop_front());
    end
  end

  initial begin
    #(5.0 * 150000);
    check("watchdog timeout", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, s, f, q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(5'h04, v); check("R1 prescaler", v, 0);
    rd(5'h08, v); check("R1 reload", v, 16'hFFF);
    rd(5'h0C, v); check("R1 status", v, 0);
    check("R1 rst_req", int'(rst_req), 0);
    // R9 key, window and unmapped read zero
    rd(5'h00, v); check("R9 key reads 0", v, 0);
    rd(5'h10, v); check("R9 window reads 0", v, 0);
    rd(5'h14, v); check("R9 unmapped reads 0", v, 0);
    // R2 locked writes ignored
    wr(5'h08, 16'h0009);
    rd(5'h08, v); check("R2 locked reload", v, 16'hFFF);
    wr(5'h04, 16'h0003);
    rd(5'h04, v); check("R2 locked prescaler", v, 0);
    // R3 unknown key does not unlock
    wr(5'h00, 16'h1234);
    wr(5'h08, 16'h0009);
    rd(5'h08, v); check("R3 odd key ignored", v, 16'hFFF);
    rd(5'h0C, v); check("R3 status untouched", v, 0);
    // R2/R8 unlock and reload update latency
    wr(5'h00, 16'h5555);
    wr(5'h08, 16'h0009);
    rd(5'h08, v); check("R2 unlocked reload", v, 9);
    rd(5'h0C, v); check("R8 reload busy at once", v, 2);
    repeat (3) @(negedge clk);
    rd(5'h0C, v); check("R8 reload busy 3 later", v, 2);
    @(negedge clk);
    rd(5'h0C, v); check("R8 reload clear 4 later", v, 0);
    // R2 lock again
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0005);
    rd(5'h08, v); check("R2 relocked reload", v, 9);
    check("R4 idle no pulse", int'(rst_req), 0);
    // R4/R5 start: (9+1)*4 = 40 cycles
    wr(5'h00, 16'hCCCC);
    s = last_edge;
    expect_pulse(s + 40);
    expect_pulse(s + 80);
    wait_until(s + 85);
    check("R5 pulses consumed", exp_q.size(), 0);
    // R6 refresh
    wr(5'h00, 16'hAAAA);
    f = last_edge;
    expect_pulse(f + 40);
    expect_pulse(f + 80);
    // R4 lock key and junk cannot stop it
    wr(5'h00, 16'h0000);
    wr(5'h00, 16'hFFFF);
    wr(5'h00, 16'hCCCC);
    wait_until(f + 85);
    check("R6 pulses consumed", exp_q.size(), 0);
    // R7/R8 prescaler code 1 -> divide by 8
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'h0001);
    rd(5'h0C, v); check("R8 prescaler busy", v, 1);
    repeat (4) @(negedge clk);
    rd(5'h0C, v); check("R8 prescaler clear", v, 0);
    rd(5'h04, v); check("R7 prescaler code", v, 1);
    wr(5'h00, 16'hAAAA);
    q = last_edge;
    expect_pulse(q + 80);
    expect_pulse(q + 160);
    wait_until(q + 170);
    check("R7 divide-by-8 pulses consumed", exp_q.size(), 0);
    // R7 code 7 -> 256, reload 0: period 256
    wr(5'h04, 16'h0007);
    wr(5'h08, 16'h0000);
    repeat (5) @(negedge clk);
    wr(5'h00, 16'hAAAA);
    q = last_edge;
    expect_pulse(q + 256);
    wait_until(q + 260);
    check("R7 code 7 pulses consumed", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule